// File: doc/BRIEF.md
# Interrupt Stacking and Wait Sequencer

This block runs the multi-cycle memory side of three processor operations: the software interrupt, the wait-for-interrupt and the return from an interrupt. When a software interrupt starts, it writes the register frame to a byte-wide stack through a single memory port. It then sets the interrupt mask bit and reads a two-byte handler address into the program counter. Wait-for-interrupt writes the same frame ahead of time and then idles with its wait indicator raised. A later interrupt therefore goes straight to the vector read. Return-from-interrupt reads the frame back and hands out every restored register, the condition codes included.

The surrounding core supplies the program counter, which is already advanced to the return address, together with the index register, both accumulators, the condition codes and the stack pointer. It pulses one command and then waits for the one-cycle completion pulse. The results stay on the result outputs until the next command is accepted. The memory port is a valid/ready channel. A transfer happens on a cycle where both are high. While valid is high and ready is low, the sequencer holds the address, write flag and write data steady and does not advance. Read data is taken from the read bus on the accepting cycle.

Top module: `isw_seq`

## Requirements
- R1: After reset the block is idle: bus_valid, busy, waiting and done are all low.
- R2: A software interrupt or wait command writes seven bytes at addresses SP, SP-1, down to SP-6. The bytes are, in that order: PC low, PC high, X low, X high, A, B, then the condition code byte. The resulting stack pointer is SP-7.
- R3: After its writes, a software interrupt reads the handler high byte from 0xFFFA and the low byte from 0xFFFB. It reports that value on new_pc and reports the condition code byte with bit 4 (the interrupt mask) set.
- R4: After its writes, a wait command raises waiting and issues no bus transfer until an interrupt ends the wait.
- R5: A wait ends on nmi through the vector at 0xFFFC/0xFFFD. It ends on irq with the mask bit clear through 0xFFF8/0xFFF9. When both are high, nmi wins. On exit the mask bit is set in new_ccr.
- R6: While the captured mask bit (condition code bit 4) is set, irq alone does not end the wait.
- R7: A return command reads addresses SP+1 to SP+7. Those bytes are taken as the condition codes, B, A, X high, X low, PC high and PC low. They are reported on the result outputs, and new_sp is SP+7.
- R8: While bus_valid is high and bus_ready is low, bus_valid, bus_addr, bus_write and bus_wdata stay unchanged on the next cycle, and the sequence does not advance.
- R9: Commands arriving while busy (waiting included) are ignored. Of simultaneous commands, software interrupt beats wait, which beats return.
- R10: done is high for exactly one cycle per completed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_swi | input | 1 | Start software interrupt |
| cmd_wai | input | 1 | Start wait-for-interrupt |
| cmd_rti | input | 1 | Start return from interrupt |
| cur_pc | input | 16 | Return address to stack |
| cur_sp | input | 16 | Current stack pointer |
| cur_x | input | 16 | Index register |
| cur_a | input | 8 | Accumulator A |
| cur_b | input | 8 | Accumulator B |
| cur_ccr | input | 8 | Condition codes; bit 4 is the interrupt mask |
| irq | input | 1 | Maskable interrupt request |
| nmi | input | 1 | Non-maskable interrupt request |
| bus_valid | output | 1 | Memory transfer offered |
| bus_ready | input | 1 | Memory accepts the transfer |
| bus_write | output | 1 | High for write, low for read |
| bus_addr | output | 16 | Transfer address |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte, valid on accepting cycle |
| busy | output | 1 | A sequence is in progress |
| waiting | output | 1 | Frame stacked, waiting for an interrupt |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 16 | Loaded program counter |
| new_sp | output | 16 | Updated stack pointer |
| new_x | output | 16 | Index register result |
| new_a | output | 8 | Accumulator A result |
| new_b | output | 8 | Accumulator B result |
| new_ccr | output | 8 | Condition code result |

## Verification
The bench uses the default parameters: 16-bit addresses, 8-bit data, mask at bit 4, and the three vectors at 0xFFF8, 0xFFFA and 0xFFFC. With these values it can tell the three handler addresses apart in one small memory model. A 256-byte stack window holds a pushed frame, and the next return command reads that same frame back. The fixed frame size of seven bytes makes the push and pull address sequences and the final stack pointer exact numbers. Changing the mask bit or a vector parameter would move the same checks to other values.

// File: rtl/isw_pkg.sv
package isw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH, ST_WAIT, ST_VHI, ST_VLO, ST_PULL
  } isw_state_e;

  typedef enum logic [1:0] {
    OP_SWI, OP_WAI, OP_RTI
  } isw_op_e;

  localparam int FRAME_N = 7;
  localparam logic [2:0] SL_PCL = 3'd0;
  localparam logic [2:0] SL_PCH = 3'd1;
  localparam logic [2:0] SL_XL  = 3'd2;
  localparam logic [2:0] SL_XH  = 3'd3;
  localparam logic [2:0] SL_A   = 3'd4;
  localparam logic [2:0] SL_B   = 3'd5;
  localparam logic [2:0] SL_CCR = 3'd6;
endpackage

// File: rtl/isw_frame.sv
module isw_frame
  import isw_pkg::*;
#(
  parameter int DW       = 8,
  parameter int MASK_BIT = 4,
  localparam int WW      = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] ld_pc,
  input  logic [WW-1:0] ld_x,
  input  logic [DW-1:0] ld_a,
  input  logic [DW-1:0] ld_b,
  input  logic [DW-1:0] ld_ccr,
  input  logic          wr_en,
  input  logic [2:0]    wr_slot,
  input  logic [DW-1:0] wr_byte,
  input  logic          set_mask,
  input  logic [2:0]    rd_slot,
  output logic [DW-1:0] rd_byte,
  output logic [WW-1:0] pc,
  output logic [WW-1:0] x,
  output logic [DW-1:0] a,
  output logic [DW-1:0] b,
  output logic [DW-1:0] ccr
);
  logic [DW-1:0] slot_q [FRAME_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FRAME_N; i++) slot_q[i] <= '0;
    end else if (load) begin
      slot_q[SL_PCL] <= ld_pc[DW-1:0];
      slot_q[SL_PCH] <= ld_pc[WW-1:DW];
      slot_q[SL_XL]  <= ld_x[DW-1:0];
      slot_q[SL_XH]  <= ld_x[WW-1:DW];
      slot_q[SL_A]   <= ld_a;
      slot_q[SL_B]   <= ld_b;
      slot_q[SL_CCR] <= ld_ccr;
    end else begin
      if (wr_en) slot_q[wr_slot] <= wr_byte;
      if (set_mask) slot_q[SL_CCR][MASK_BIT] <= 1'b1;
    end
  end

  always_comb begin
    rd_byte = slot_q[rd_slot];
    pc  = {slot_q[SL_PCH], slot_q[SL_PCL]};
    x   = {slot_q[SL_XH], slot_q[SL_XL]};
    a   = slot_q[SL_A];
    b   = slot_q[SL_B];
    ccr = slot_q[SL_CCR];
  end

  p_no_slot_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && set_mask && wr_slot == SL_CCR));
endmodule

// File: rtl/isw_wake_arb.sv
module isw_wake_arb #(
  parameter int          AW      = 16,
  parameter logic [AW-1:0] VEC_NMI = 16'hFFFC,
  parameter logic [AW-1:0] VEC_IRQ = 16'hFFF8
) (
  input  logic          armed,
  input  logic          masked,
  input  logic          nmi,
  input  logic          irq,
  output logic          wake,
  output logic [AW-1:0] wake_vec
);
  always_comb begin
    wake     = 1'b0;
    wake_vec = VEC_IRQ;
    if (armed) begin
      if (nmi) begin
        wake     = 1'b1;
        wake_vec = VEC_NMI;
      end else if (irq && !masked) begin
        wake     = 1'b1;
        wake_vec = VEC_IRQ;
      end
    end
  end

  always_comb begin
    if (wake && nmi) assert (wake_vec == VEC_NMI) else $error("p_nmi_first_r5");
  end
endmodule

// File: rtl/isw_bus_gen.sv
module isw_bus_gen
  import isw_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  isw_state_e    state,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] vec,
  input  logic [DW-1:0] push_byte,
  output logic          valid,
  output logic          write,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);
  always_comb begin
    valid = 1'b0;
    write = 1'b0;
    addr  = '0;
    wdata = '0;
    unique case (state)
      ST_PUSH: begin
        valid = 1'b1;
        write = 1'b1;
        addr  = sp;
        wdata = push_byte;
      end
      ST_PULL: begin
        valid = 1'b1;
        addr  = sp + AW'(1);
      end
      ST_VHI: begin
        valid = 1'b1;
        addr  = vec;
      end
      ST_VLO: begin
        valid = 1'b1;
        addr  = vec + AW'(1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/isw_seq.sv
module isw_seq
  import isw_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          MASK_BIT = 4,
  parameter logic [15:0] VEC_IRQ  = 16'hFFF8,
  parameter logic [15:0] VEC_SWI  = 16'hFFFA,
  parameter logic [15:0] VEC_NMI  = 16'hFFFC,
  localparam int         ADDR_W   = 2 * DATA_W,
  localparam int         IDX_W    = $clog2(FRAME_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_swi,
  input  logic              cmd_wai,
  input  logic              cmd_rti,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] cur_sp,
  input  logic [ADDR_W-1:0] cur_x,
  input  logic [DATA_W-1:0] cur_a,
  input  logic [DATA_W-1:0] cur_b,
  input  logic [DATA_W-1:0] cur_ccr,
  input  logic              irq,
  input  logic              nmi,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              waiting,
  output logic              done,
  output logic [ADDR_W-1:0] new_pc,
  output logic [ADDR_W-1:0] new_sp,
  output logic [ADDR_W-1:0] new_x,
  output logic [DATA_W-1:0] new_a,
  output logic [DATA_W-1:0] new_b,
  output logic [DATA_W-1:0] new_ccr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_N - 1);

  isw_state_e        state_q;
  isw_op_e           op_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] vec_q;
  logic              done_q;

  logic              accept, start, last, wake, set_mask, wr_en;
  logic [ADDR_W-1:0] wake_vec;
  logic [2:0]        wr_slot;
  logic [DATA_W-1:0] push_byte;

  assign accept = bus_valid && bus_ready;
  assign start  = (state_q == ST_IDLE) && (cmd_swi || cmd_wai || cmd_rti);
  assign last   = (idx_q == LAST);

  isw_wake_arb #(.AW(ADDR_W), .VEC_NMI(VEC_NMI), .VEC_IRQ(VEC_IRQ)) u_arb (
    .armed    (state_q == ST_WAIT),
    .masked   (new_ccr[MASK_BIT]),
    .nmi      (nmi),
    .irq      (irq),
    .wake     (wake),
    .wake_vec (wake_vec)
  );

  isw_bus_gen #(.AW(ADDR_W), .DW(DATA_W)) u_bus (
    .state     (state_q),
    .sp        (sp_q),
    .vec       (vec_q),
    .push_byte (push_byte),
    .valid     (bus_valid),
    .write     (bus_write),
    .addr      (bus_addr),
    .wdata     (bus_wdata)
  );

  always_comb begin
    wr_en    = accept && (state_q inside {ST_VHI, ST_VLO, ST_PULL});
    wr_slot  = (state_q == ST_VHI) ? SL_PCH :
               (state_q == ST_VLO) ? SL_PCL : 3'(LAST - idx_q);
    set_mask = (state_q == ST_PUSH && accept && last && op_q != OP_WAI) ||
               (state_q == ST_WAIT && wake);
  end

  isw_frame #(.DW(DATA_W), .MASK_BIT(MASK_BIT)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .ld_pc    (cur_pc),
    .ld_x     (cur_x),
    .ld_a     (cur_a),
    .ld_b     (cur_b),
    .ld_ccr   (cur_ccr),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .wr_byte  (bus_rdata),
    .set_mask (set_mask),
    .rd_slot  (3'(idx_q)),
    .rd_byte  (push_byte),
    .pc       (new_pc),
    .x        (new_x),
    .a        (new_a),
    .b        (new_b),
    .ccr      (new_ccr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_SWI;
      idx_q   <= '0;
      sp_q    <= '0;
      vec_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          sp_q  <= cur_sp;
          idx_q <= '0;
          if (cmd_swi) begin
            op_q <= OP_SWI; state_q <= ST_PUSH;
          end else if (cmd_wai) begin
            op_q <= OP_WAI; state_q <= ST_PUSH;
          end else begin
            op_q <= OP_RTI; state_q <= ST_PULL;
          end
        end
        ST_PUSH: if (accept) begin
          sp_q <= sp_q - ADDR_W'(1);
          if (last) begin
            idx_q <= '0;
            if (op_q == OP_WAI) state_q <= ST_WAIT;
            else begin
              vec_q   <= VEC_SWI;
              state_q <= ST_VHI;
            end
          end else idx_q <= idx_q + IDX_W'(1);
        end
        ST_WAIT: if (wake) begin
          vec_q   <= wake_vec;
          state_q <= ST_VHI;
        end
        ST_VHI: if (accept) state_q <= ST_VLO;
        ST_VLO: if (accept) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_PULL: if (accept) begin
          sp_q <= sp_q + ADDR_W'(1);
          if (last) begin
            idx_q   <= '0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else idx_q <= idx_q + IDX_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign waiting = (state_q == ST_WAIT);
  assign done    = done_q;
  assign new_sp  = sp_q;

  p_hold_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
                               $stable(bus_wdata) && $stable(bus_write));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_wait_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !bus_valid);
  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && !nmi && new_ccr[MASK_BIT] |=> waiting);
  p_exit_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_q != OP_RTI |-> new_ccr[MASK_BIT]);
  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_PUSH && accept |=> sp_q == $past(sp_q) - ADDR_W'(1));
  p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && !wake |=> waiting);
endmodule

// File: tb/test_isw_seq.sv
module test_isw_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_swi = 0, cmd_wai = 0, cmd_rti = 0;
  logic [15:0] cur_pc = 16'h4102, cur_sp = 16'h00F0, cur_x = 16'hA55A;
  logic [7:0]  cur_a = 8'h11, cur_b = 8'h22, cur_ccr = 8'hC1;
  logic irq = 0, nmi = 0, bus_ready = 1;
  logic bus_valid, bus_write, busy, waiting, done;
  logic [15:0] bus_addr, new_pc, new_sp, new_x;
  logic [7:0]  bus_wdata, bus_rdata, new_a, new_b, new_ccr;

  int checks = 0, errors = 0, cyc = 0, ready_mode = 0;
  logic [7:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  isw_seq i_isw_seq (
    .clk(clk), .rst_n(rst_n), .cmd_swi(cmd_swi), .cmd_wai(cmd_wai), .cmd_rti(cmd_rti),
    .cur_pc(cur_pc), .cur_sp(cur_sp), .cur_x(cur_x), .cur_a(cur_a), .cur_b(cur_b),
    .cur_ccr(cur_ccr), .irq(irq), .nmi(nmi), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .waiting(waiting), .done(done), .new_pc(new_pc), .new_sp(new_sp),
    .new_x(new_x), .new_a(new_a), .new_b(new_b), .new_ccr(new_ccr));

  always_comb begin
    case (bus_addr)
      16'hFFF8: bus_rdata = 8'h12;
      16'hFFF9: bus_rdata = 8'h34;
      16'hFFFA: bus_rdata = 8'h56;
      16'hFFFB: bus_rdata = 8'h78;
      16'hFFFC: bus_rdata = 8'h9A;
      16'hFFFD: bus_rdata = 8'hBC;
      default:  bus_rdata = mem[bus_addr[7:0]];
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_valid && bus_ready && bus_write) mem[bus_addr[7:0]] <= bus_wdata;
  end

  always @(negedge clk)
    bus_ready <= (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? cyc[0] : 1'b0;

  always @(posedge clk) if (cyc > 60000) begin
    errors++;
    $display("FAIL watchdog: run hung, act cycle %0d exp < 60000", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic s, input logic w, input logic r);
    @(negedge clk);
    cmd_swi = s; cmd_wai = w; cmd_rti = r;
    @(negedge clk);
    cmd_swi = 0; cmd_wai = 0; cmd_rti = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    if (!done) chk({tag, " done timeout"}, 0, 1);
  endtask

  task automatic wait_waiting;
    int n = 0;
    while (!waiting && n < 3000) begin @(negedge clk); n++; end
  endtask

  // op(2) ccr(8) sp(16) irq nmi exp_pc(16) exp_ccr(8) exp_sp(16); op 0 swi, 1 wai, 2 rti
  localparam int NV = 5;
  localparam logic [67:0] VECS [NV] = '{
    {2'd0, 8'hC1, 16'h00F0, 1'b0, 1'b0, 16'h5678, 8'hD1, 16'h00E9},
    {2'd1, 8'hC1, 16'h00F0, 1'b1, 1'b0, 16'h1234, 8'hD1, 16'h00E9},
    {2'd1, 8'hD1, 16'h00F0, 1'b1, 1'b1, 16'h9ABC, 8'hD1, 16'h00E9},
    {2'd1, 8'hC1, 16'h00F0, 1'b1, 1'b1, 16'h9ABC, 8'hD1, 16'h00E9},
    {2'd2, 8'h00, 16'h00E9, 1'b0, 1'b0, 16'h4102, 8'hC1, 16'h00F0}
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    step(3);
    // R1 reset state
    chk("R1 valid", bus_valid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 waiting", waiting, 0);
    chk("R1 done", done, 0);
    rst_n = 1;
    step(2);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op; logic ei, en;
      logic [15:0] epc, esp; logic [7:0] eccr;
      {op, cur_ccr, cur_sp, ei, en, epc, eccr, esp} = VECS[v];
      ready_mode = v % 2;
      if (op == 2) begin cur_x = 0; cur_a = 0; cur_b = 0; cur_pc = 0; end
      else begin cur_x = 16'hA55A; cur_a = 8'h11; cur_b = 8'h22; cur_pc = 16'h4102; end
      pulse(op == 0, op == 1, op == 2);
      if (op == 1) begin
        wait_waiting();
        chk("R4 waiting", waiting, 1);
        @(negedge clk); irq = ei; nmi = en;
      end
      wait_done("R3 R5 R7");
      irq = 0; nmi = 0;
      chk("R3 R5 R7 pc", new_pc, epc);
      chk("R3 R5 R7 ccr", new_ccr, eccr);
      chk("R2 R7 sp", new_sp, esp);
      if (op == 2) begin
        chk("R7 x", new_x, 16'hA55A);
        chk("R7 a", new_a, 8'h11);
        chk("R7 b", new_b, 8'h22);
      end
      if (v == 0) begin
        chk("R2 pcl", mem[8'hF0], 8'h02); chk("R2 pch", mem[8'hEF], 8'h41);
        chk("R2 xl", mem[8'hEE], 8'h5A);  chk("R2 xh", mem[8'hED], 8'hA5);
        chk("R2 a", mem[8'hEC], 8'h11);   chk("R2 b", mem[8'hEB], 8'h22);
        chk("R2 ccr", mem[8'hEA], 8'hC1);
      end
      @(negedge clk);
      chk("R10 pulse", done, 0);
    end

    // R8 back-pressure: no ready, offer must hold
    ready_mode = 2; cur_ccr = 8'hC1; cur_sp = 16'h00F0;
    cur_x = 16'hA55A; cur_a = 8'h11; cur_b = 8'h22; cur_pc = 16'h4102;
    pulse(1, 0, 0);
    step(4);
    chk("R8 valid", bus_valid, 1);
    chk("R8 addr", bus_addr, 16'h00F0);
    chk("R8 data", bus_wdata, 8'h02);
    chk("R8 write", bus_write, 1);
    ready_mode = 0;
    wait_done("R8");
    step(1);

    // R6 masked irq ignored; R9 command during wait ignored
    cur_ccr = 8'hD1;
    pulse(0, 1, 0);
    wait_waiting();
    irq = 1;
    step(20);
    chk("R6 still waiting", waiting, 1);
    chk("R6 no done", done, 0);
    chk("R4 bus idle", bus_valid, 0);
    pulse(0, 0, 1);
    step(2);
    chk("R9 ignored waiting", waiting, 1);
    chk("R9 ignored bus", bus_valid, 0);
    nmi = 1;
    wait_done("R5");
    nmi = 0; irq = 0;
    chk("R5 nmi pc", new_pc, 16'h9ABC);
    step(1);

    // R9 simultaneous: swi beats wai
    cur_ccr = 8'hC1;
    pulse(1, 1, 0);
    wait_done("R9");
    chk("R9 swi wins pc", new_pc, 16'h5678);
    chk("R9 not waiting", waiting, 0);
    step(1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule